// File: doc/BRIEF.md
# Banked Multi-Queue Message Buffer

A shared message store split among several output queues. Each queue is a circular FIFO built from a contiguous run of 32-entry chunks. Every run lies inside one 1024-entry region. A configuration port gives a queue its region, its first chunk and its last chunk. A push port writes one entry at the tail of the queue it names. A pop port reads one entry from the head of the queue it names. Each queue reports whether it is empty and whether it is full.

The storage is eight single-port banks, each with a one-cycle access. Consecutive entries of a queue fall in consecutive banks. A push and a pop can therefore complete in the same cycle whenever they touch different banks. When they touch the same bank, the pop is served and the push is held off by dropping `push_ready`. The number of regions, the queue count and the entry width are parameters. Thirty-two regions give a 32K-entry store; the default is smaller.

Top module: `mq_buffer`

## Requirements
- R1: After reset every queue is empty and not full. `push_ready` is high, and `cfg_reject`, `push_err`, `pop_err` and `pop_data_valid` are low. Each queue's reset configuration is chunk 0 of region 0, which holds 32 entries.
- R2: A configuration with `cfg_last >= cfg_first` and a region below NUM_REGIONS is accepted. The queue then holds (cfg_last - cfg_first + 1) * 32 entries. Its head, tail and count return to the first entry of `cfg_first`, so the queue reads as empty from the next cycle.
- R3: A configuration with `cfg_last < cfg_first` is rejected. `cfg_reject` pulses one cycle later, and the queue keeps its previous region, chunks and stored entries.
- R4: An accepted push writes at the queue's tail. Pops return a queue's entries in push order. `pop_data` is valid with `pop_data_valid` high in the cycle after the pop is accepted.
- R5: When a head or tail pointer leaves the last entry of the last chunk, it wraps to the first entry of the first chunk, and push order is preserved across the wrap.
- R6: `q_full` is high when the count equals the configured size. A push to a full queue is dropped, leaves the queue unchanged, and raises `push_err` for one cycle, one cycle later.
- R7: A pop from an empty queue is dropped. `pop_err` pulses one cycle later and `pop_data_valid` stays low.
- R8: The bank of an entry is the low 3 bits of its entry index. If a served pop and a push map to the same bank in one cycle, `push_ready` is low in that cycle and the push is not taken.
- R9: A push and a served pop that map to different banks both complete in the same cycle, including when both name the same queue.
- R10: While `cfg_valid` is high, `push_ready` is low and `pop_valid` is ignored: no read, no `pop_err` and no change to any queue other than the one being configured.
- R11: Queues in different regions, or in disjoint chunks of one region, keep separate contents and flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | Configuration request |
| cfg_qid | input | QID_W | Queue being configured |
| cfg_region | input | RG_W | 1024-entry region of the queue |
| cfg_first | input | 5 | First chunk in the region |
| cfg_last | input | 5 | Last chunk in the region |
| cfg_reject | output | 1 | Configuration refused (one-cycle pulse) |
| push_valid | input | 1 | Push request |
| push_qid | input | QID_W | Queue to push into |
| push_data | input | DATA_W | Entry to write |
| push_ready | output | 1 | Push can be taken this cycle |
| push_err | output | 1 | Push hit a full queue (one-cycle pulse) |
| pop_valid | input | 1 | Pop request |
| pop_qid | input | QID_W | Queue to pop from |
| pop_data | output | DATA_W | Entry read by the previous cycle's pop |
| pop_data_valid | output | 1 | pop_data holds a popped entry |
| pop_err | output | 1 | Pop hit an empty queue (one-cycle pulse) |
| q_empty | output | NUM_Q | Per-queue empty flags |
| q_full | output | NUM_Q | Per-queue full flags |

## Verification
`push_ready` is combinational. The bench reads it 1 ns after it drives a request at the falling edge, before the rising edge that would accept the push. Every other result appears one rising edge after its request: the queue flags, `cfg_reject`, `push_err`, `pop_err`, and `pop_data` with `pop_data_valid`. The bench checks them at the falling edge that follows that rising edge, just after it has withdrawn the request. A per-queue reference list in the bench gives each expected value.

// File: rtl/mq_pkg.sv
package mq_pkg;
    localparam int CHK_W     = 5;             // chunk index inside a region
    localparam int OFS_W     = 5;             // entry offset inside a chunk
    localparam int PTR_W     = CHK_W + OFS_W; // entry index inside a region
    localparam int BSEL_W    = 3;             // bank select bits
    localparam int NUM_BANKS = 1 << BSEL_W;
    localparam int CNT_W     = PTR_W + 1;

    typedef struct packed {
        logic [CHK_W-1:0] first;
        logic [CHK_W-1:0] last;
    } span_t;

    function automatic logic [CNT_W-1:0] span_entries(span_t s);
        return (CNT_W'(s.last) - CNT_W'(s.first) + CNT_W'(1)) << OFS_W;
    endfunction

    function automatic logic [PTR_W-1:0] next_ptr(logic [PTR_W-1:0] p, span_t s);
        if (p == {s.last, {OFS_W{1'b1}}})
            return {s.first, {OFS_W{1'b0}}};
        return p + PTR_W'(1);
    endfunction
endpackage

// File: rtl/mq_bank.sv
module mq_bank #(
    parameter int DATA_W = 16,
    parameter int ROWS   = 256,
    parameter int ROW_W  = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [ROW_W-1:0]  row,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [ROWS];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem[row] <= wdata;
            else    rdata    <= mem[row];
        end
    end
endmodule

// File: rtl/mq_ctx.sv
module mq_ctx
    import mq_pkg::*;
#(
    parameter int NUM_Q = 4,
    parameter int RG_W  = 1,
    parameter int QID_W = $clog2(NUM_Q),
    parameter int ENT_W = RG_W + PTR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [QID_W-1:0] cfg_qid,
    input  logic [RG_W-1:0]  cfg_rg,
    input  span_t            cfg_span,
    input  logic             push_go,
    input  logic [QID_W-1:0] push_qid,
    input  logic             pop_go,
    input  logic [QID_W-1:0] pop_qid,
    output logic [ENT_W-1:0] push_ent,
    output logic             push_full,
    output logic [ENT_W-1:0] pop_ent,
    output logic             pop_empty,
    output logic [NUM_Q-1:0] q_empty,
    output logic [NUM_Q-1:0] q_full
);
    span_t            span_q [NUM_Q];
    logic [RG_W-1:0]  rg_q   [NUM_Q];
    logic [PTR_W-1:0] head_q [NUM_Q];
    logic [PTR_W-1:0] tail_q [NUM_Q];
    logic [CNT_W-1:0] cnt_q  [NUM_Q];

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_Q; i++) begin
            if (rst) begin
                span_q[i] <= '0;
                rg_q[i]   <= '0;
                head_q[i] <= '0;
                tail_q[i] <= '0;
                cnt_q[i]  <= '0;
            end else if (cfg_we && cfg_qid == QID_W'(i)) begin
                span_q[i] <= cfg_span;
                rg_q[i]   <= cfg_rg;
                head_q[i] <= {cfg_span.first, {OFS_W{1'b0}}};
                tail_q[i] <= {cfg_span.first, {OFS_W{1'b0}}};
                cnt_q[i]  <= '0;
            end else begin
                if (push_go && push_qid == QID_W'(i))
                    tail_q[i] <= next_ptr(tail_q[i], span_q[i]);
                if (pop_go && pop_qid == QID_W'(i))
                    head_q[i] <= next_ptr(head_q[i], span_q[i]);
                cnt_q[i] <= cnt_q[i]
                          + CNT_W'(push_go && push_qid == QID_W'(i))
                          - CNT_W'(pop_go && pop_qid == QID_W'(i));
            end
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_Q; i++) begin
            q_empty[i] = (cnt_q[i] == '0);
            q_full[i]  = (cnt_q[i] == span_entries(span_q[i]));
        end
    end

    assign push_ent  = {rg_q[push_qid], tail_q[push_qid]};
    assign pop_ent   = {rg_q[pop_qid], head_q[pop_qid]};
    assign push_full = q_full[push_qid];
    assign pop_empty = q_empty[pop_qid];

    for (genvar g = 0; g < NUM_Q; g++) begin : g_chk
        p_count_bound_r6: assert property (@(posedge clk) disable iff (rst)
            cnt_q[g] <= span_entries(span_q[g]));
        p_cfg_empties_r2: assert property (@(posedge clk) disable iff (rst)
            cfg_we && cfg_qid == QID_W'(g) |=> cnt_q[g] == '0);
        p_head_in_span_r5: assert property (@(posedge clk) disable iff (rst)
            head_q[g][PTR_W-1:OFS_W] >= span_q[g].first &&
            head_q[g][PTR_W-1:OFS_W] <= span_q[g].last);
    end
endmodule

// File: rtl/mq_buffer.sv
module mq_buffer
    import mq_pkg::*;
#(
    parameter int NUM_Q       = 4,
    parameter int DATA_W      = 16,
    parameter int NUM_REGIONS = 2,
    parameter int QID_W       = $clog2(NUM_Q),
    parameter int RG_W        = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_valid,
    input  logic [QID_W-1:0]  cfg_qid,
    input  logic [RG_W-1:0]   cfg_region,
    input  logic [4:0]        cfg_first,
    input  logic [4:0]        cfg_last,
    output logic              cfg_reject,
    input  logic              push_valid,
    input  logic [QID_W-1:0]  push_qid,
    input  logic [DATA_W-1:0] push_data,
    output logic              push_ready,
    output logic              push_err,
    input  logic              pop_valid,
    input  logic [QID_W-1:0]  pop_qid,
    output logic [DATA_W-1:0] pop_data,
    output logic              pop_data_valid,
    output logic              pop_err,
    output logic [NUM_Q-1:0]  q_empty,
    output logic [NUM_Q-1:0]  q_full
);
    localparam int ENT_W = RG_W + PTR_W;
    localparam int ROW_W = ENT_W - BSEL_W;
    localparam int ROWS  = (NUM_REGIONS << PTR_W) / NUM_BANKS;

    logic              cfg_ok, push_go, pop_go, push_full, pop_empty;
    logic [ENT_W-1:0]  push_ent, pop_ent;
    logic [BSEL_W-1:0] push_bank, pop_bank, pop_bank_q;
    span_t             cfg_span;
    logic              bank_en [NUM_BANKS];
    logic              bank_we [NUM_BANKS];
    logic [ROW_W-1:0]  bank_row [NUM_BANKS];
    logic [DATA_W-1:0] bank_rd [NUM_BANKS];

    assign cfg_span   = '{first: cfg_first, last: cfg_last};
    assign cfg_ok     = cfg_valid && (cfg_last >= cfg_first) && (32'(cfg_region) < NUM_REGIONS);
    assign push_bank  = push_ent[BSEL_W-1:0];
    assign pop_bank   = pop_ent[BSEL_W-1:0];
    assign pop_go     = pop_valid && !cfg_valid && !pop_empty;
    assign push_ready = !cfg_valid && !(pop_go && pop_bank == push_bank);
    assign push_go    = push_valid && push_ready && !push_full;

    mq_ctx #(.NUM_Q(NUM_Q), .RG_W(RG_W), .QID_W(QID_W), .ENT_W(ENT_W)) u_ctx (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_ok), .cfg_qid(cfg_qid), .cfg_rg(cfg_region), .cfg_span(cfg_span),
        .push_go(push_go), .push_qid(push_qid),
        .pop_go(pop_go), .pop_qid(pop_qid),
        .push_ent(push_ent), .push_full(push_full),
        .pop_ent(pop_ent), .pop_empty(pop_empty),
        .q_empty(q_empty), .q_full(q_full)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic pop_hit, push_hit;
        assign pop_hit     = pop_go && pop_bank == BSEL_W'(b);
        assign push_hit    = push_go && push_bank == BSEL_W'(b);
        assign bank_en[b]  = pop_hit || push_hit;
        assign bank_we[b]  = !pop_hit;
        assign bank_row[b] = pop_hit ? pop_ent[ENT_W-1:BSEL_W] : push_ent[ENT_W-1:BSEL_W];

        mq_bank #(.DATA_W(DATA_W), .ROWS(ROWS), .ROW_W(ROW_W)) u_bank (
            .clk(clk), .en(bank_en[b]), .we(bank_we[b]), .row(bank_row[b]),
            .wdata(push_data), .rdata(bank_rd[b])
        );

        p_one_access_r8: assert property (@(posedge clk) disable iff (rst)
            !(pop_hit && push_hit));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_reject     <= 1'b0;
            push_err       <= 1'b0;
            pop_err        <= 1'b0;
            pop_data_valid <= 1'b0;
            pop_bank_q     <= '0;
        end else begin
            cfg_reject     <= cfg_valid && !cfg_ok;
            push_err       <= push_valid && push_ready && push_full;
            pop_err        <= pop_valid && !cfg_valid && pop_empty;
            pop_data_valid <= pop_go;
            pop_bank_q     <= pop_bank;
        end
    end

    assign pop_data = bank_rd[pop_bank_q];

    p_cfg_blocks_push_r10: assert property (@(posedge clk) disable iff (rst)
        cfg_valid |-> !push_ready);
    p_data_follows_pop_r4: assert property (@(posedge clk) disable iff (rst)
        pop_data_valid |-> $past(pop_valid) && !$past(cfg_valid));
    p_err_no_data_r7: assert property (@(posedge clk) disable iff (rst)
        pop_err |-> !pop_data_valid);
    p_flags_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
        (q_empty & q_full) == '0);
    p_reject_silent_r3: assert property (@(posedge clk) disable iff (rst)
        cfg_valid && cfg_last < cfg_first |=> cfg_reject);
endmodule

// File: tb/tb_mq_buffer.sv
`timescale 1ns/1ps
module tb_mq_buffer;
    localparam int NQ = 4;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_valid = 1'b0;
    logic [1:0]    cfg_qid = '0;
    logic [0:0]    cfg_region = '0;
    logic [4:0]    cfg_first = '0, cfg_last = '0;
    logic          cfg_reject;
    logic          push_valid = 1'b0;
    logic [1:0]    push_qid = '0;
    logic [DW-1:0] push_data = '0;
    logic          push_ready, push_err;
    logic          pop_valid = 1'b0;
    logic [1:0]    pop_qid = '0;
    logic [DW-1:0] pop_data;
    logic          pop_data_valid, pop_err;
    logic [NQ-1:0] q_empty, q_full;

    mq_buffer #(.NUM_Q(NQ), .DATA_W(DW), .NUM_REGIONS(2)) dut (
        .clk(clk), .rst(rst),
        .cfg_valid(cfg_valid), .cfg_qid(cfg_qid), .cfg_region(cfg_region),
        .cfg_first(cfg_first), .cfg_last(cfg_last), .cfg_reject(cfg_reject),
        .push_valid(push_valid), .push_qid(push_qid), .push_data(push_data),
        .push_ready(push_ready), .push_err(push_err),
        .pop_valid(pop_valid), .pop_qid(pop_qid), .pop_data(pop_data),
        .pop_data_valid(pop_data_valid), .pop_err(pop_err),
        .q_empty(q_empty), .q_full(q_full)
    );

    always #4 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    logic [DW-1:0] model [NQ][$];
    int            qsize [NQ];
    logic [DW-1:0] seq = 16'h1000;

    task automatic check(string req, longint act, longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_flags(string req);
        logic [NQ-1:0] e, f;
        for (int q = 0; q < NQ; q++) begin
            e[q] = (model[q].size() == 0);
            f[q] = (model[q].size() == qsize[q]);
        end
        check({req, " empty"}, q_empty, e);
        check({req, " full"}, q_full, f);
    endtask

    task automatic configure(int q, int rg, int f, int l, bit exp_rej, string req);
        @(negedge clk);
        cfg_valid = 1'b1; cfg_qid = 2'(q); cfg_region = 1'(rg);
        cfg_first = 5'(f); cfg_last = 5'(l);
        @(posedge clk);
        @(negedge clk);
        cfg_valid = 1'b0;
        check({req, " reject"}, cfg_reject, exp_rej);
        if (!exp_rej) begin
            model[q].delete();
            qsize[q] = (l - f + 1) * 32;
        end
        check_flags(req);
    endtask

    // one cycle of optional push and optional pop, with the expected push_ready
    task automatic cycle(bit dpush, int pq, bit dpop, int oq, bit exp_ready, string req);
        bit pop_ok, push_ok, full;
        logic [DW-1:0] exp_d;
        @(negedge clk);
        push_valid = dpush; push_qid = 2'(pq); push_data = seq;
        pop_valid  = dpop;  pop_qid  = 2'(oq);
        #1;
        if (dpush) check({req, " push_ready"}, push_ready, exp_ready);
        pop_ok  = dpop && model[oq].size() > 0;
        full    = dpush && model[pq].size() == qsize[pq];
        push_ok = dpush && exp_ready && !full;
        exp_d   = '0;
        if (pop_ok) exp_d = model[oq].pop_front();
        if (push_ok) begin
            model[pq].push_back(seq);
            seq = seq + 16'h0b3d;
        end
        @(posedge clk);
        @(negedge clk);
        push_valid = 1'b0; pop_valid = 1'b0;
        check({req, " pop_data_valid"}, pop_data_valid, pop_ok);
        if (pop_ok) check({req, " pop_data"}, pop_data, exp_d);
        check({req, " pop_err"}, pop_err, dpop && !pop_ok);
        check({req, " push_err"}, push_err, dpush && exp_ready && full);
        check_flags(req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int q = 0; q < NQ; q++) qsize[q] = 32;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check("R1 empty", q_empty, 4'hF);
        check("R1 full", q_full, 4'h0);
        check("R1 push_ready", push_ready, 1);
        check("R1 errs", {cfg_reject, push_err, pop_err, pop_data_valid}, 0);

        // R2 accepted configuration, 64 entries
        configure(0, 0, 0, 1, 1'b0, "R2");
        // R6 fill to full, then overflow
        for (int i = 0; i < 64; i++) cycle(1, 0, 0, 0, 1, "R6 fill");
        cycle(1, 0, 0, 0, 1, "R6 overflow");
        // R4 drain in order, R7 underflow
        for (int i = 0; i < 64; i++) cycle(0, 0, 1, 0, 1, "R4 drain");
        cycle(0, 0, 1, 0, 1, "R7 underflow");

        // R5 wrap: advance pointers, then fill across the end of the span
        for (int i = 0; i < 40; i++) cycle(1, 0, 0, 0, 1, "R5 pre");
        for (int i = 0; i < 40; i++) cycle(0, 0, 1, 0, 1, "R5 pre");
        for (int i = 0; i < 64; i++) cycle(1, 0, 0, 0, 1, "R5 wrap fill");
        for (int i = 0; i < 64; i++) cycle(0, 0, 1, 0, 1, "R5 wrap drain");

        // R3 rejected configuration keeps contents
        for (int i = 0; i < 3; i++) cycle(1, 0, 0, 0, 1, "R3 load");
        configure(0, 0, 5, 2, 1'b1, "R3");
        for (int i = 0; i < 3; i++) cycle(0, 0, 1, 0, 1, "R3 keep");

        // R2 reconfiguration clears a non-empty queue
        cycle(1, 0, 0, 0, 1, "R2 load");
        configure(0, 0, 0, 1, 1'b0, "R2 clear");
        cycle(0, 0, 1, 0, 1, "R2 cleared pop");

        configure(1, 0, 2, 2, 1'b0, "R2 q1");
        configure(2, 1, 31, 31, 1'b0, "R2 q2");
        configure(3, 0, 3, 3, 1'b0, "R2 q3");

        // R8: q0 head at bank 0, q1 tail at bank 0 -> push stalls
        cycle(1, 0, 0, 0, 1, "R8 load");
        cycle(1, 1, 1, 0, 0, "R8 conflict");
        // R9: q0 now head/tail at entry 1 (bank 1); q1 tail bank 0
        cycle(1, 0, 0, 0, 1, "R9 load");
        cycle(1, 1, 1, 0, 1, "R9 parallel");
        cycle(0, 0, 1, 1, 1, "R9 q1 pop");

        // R8 same queue: eight entries put head and tail in one bank
        for (int i = 0; i < 8; i++) cycle(1, 3, 0, 0, 1, "R8 q3 load");
        cycle(1, 3, 1, 3, 0, "R8 same queue");
        cycle(1, 3, 1, 3, 1, "R9 same queue");
        for (int i = 0; i < 8; i++) cycle(0, 0, 1, 3, 1, "R9 q3 drain");

        // R10: configuration cycle blocks push and ignores pop
        @(negedge clk);
        cfg_valid = 1'b1; cfg_qid = 2'd2; cfg_region = 1'd1; cfg_first = 5'd31; cfg_last = 5'd31;
        push_valid = 1'b1; push_qid = 2'd1; push_data = 16'hdead;
        pop_valid = 1'b1; pop_qid = 2'd1;
        #1;
        check("R10 push_ready", push_ready, 0);
        @(posedge clk);
        @(negedge clk);
        cfg_valid = 1'b0; push_valid = 1'b0; pop_valid = 1'b0;
        check("R10 no pop_err", pop_err, 0);
        check("R10 no data", pop_data_valid, 0);
        check("R10 no push_err", push_err, 0);
        model[2].delete();
        check_flags("R10");

        // R11: two 32-entry queues in different regions
        for (int i = 0; i < 32; i++) begin
            cycle(1, 2, 0, 0, 1, "R11 fill q2");
            cycle(1, 3, 0, 0, 1, "R11 fill q3");
        end
        for (int i = 0; i < 32; i++) begin
            cycle(0, 0, 1, 2, 1, "R11 drain q2");
            cycle(0, 0, 1, 3, 1, "R11 drain q3");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule